// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide programming front end of one eight-input priority interrupt controller. Software reaches it through a one-bit port select (command or data) and single-cycle write and read strobes. After reset, or after any command write with bit 4 set, the block walks a four-step setup sequence. It accepts only cascaded, fourth-word-required, processor-mode setups. Once that sequence has finished, it decodes mask writes and two kinds of operation command.

The block holds the mask, the base vector, auto-EOI, special fully nested mode (on the master instance only), special mask mode, the armed poll and the register-read select. It forwards end-of-interrupt and priority commands to the separate in-service logic. It returns the mask, the request register or the in-service register on reads. A read with a poll armed returns the winning pin and acknowledges that pin on a sideband. The request and in-service registers and the priority resolver live outside the block and feed it through sideband inputs.

Top module: `pic_cmd_seq`

## Requirements
- R1: Reset leaves the block not ready and waiting for the first setup word, with mask, base vector, auto-EOI, special fully nested, special mask, poll, read select and read data all zero.
- R2: A command write with bit 4 set starts setup in every state. On the next cycle the mask and special mask mode are zero, ready is low, and `init_clr_o` pulses for one cycle to tell the in-service logic to clear requests and set the lowest priority to 7. The poll is disarmed and the read select returns to the request register.
- R3: A first setup word with bit 1 set (single mode) or with bit 0 clear (no fourth word) is refused. The block stays not ready and waits for another first word, so the next data write loads the mask and leaves the base vector unchanged.
- R4: The second setup word, written to the data port, loads the base vector as the written byte ANDed with 0xF8.
- R5: The third setup word has no effect on the held state. A fourth word with bit 0 set raises ready and loads auto-EOI from bit 1. On the master instance (`IS_MASTER`=1) it also loads special fully nested mode from bit 4; on the slave instance that mode stays 0.
- R6: A fourth word with bit 0 clear is refused. Ready stays low and the block keeps waiting for the fourth word.
- R7: In the waiting-for-first-word state, a data-port write loads the mask register, which `imr_o` shows on the next cycle.
- R8: A command write while ready, with bits 4 and 3 clear, is forwarded on the next cycle as a one-cycle `ocw2_valid_o` pulse carrying the byte on `ocw2_o`. When the block is not ready, no such pulse is produced.
- R9: A command write while ready, with bit 4 clear and bit 3 set, is an operation-control word. Bit 5 is loaded into special mask mode only if bit 6 is set. Bit 0 is loaded into the read select (1 = in-service) only if bit 1 is set. Bit 2 arms a one-shot poll.
- R10: A read while a poll is armed disarms the poll. If `win_valid_i` is high, the read returns 0x80 OR the winning pin, and `poll_ack_o` pulses with that pin on `poll_pin_o`. Otherwise it returns 0 and does not acknowledge.
- R11: With no poll armed, a data-port read returns the mask. A command-port read returns `isr_i` when the read select is set and `irr_i` when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 1 | Port select: 0 command, 1 data |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irr_i | input | 8 | Request register from in-service logic |
| isr_i | input | 8 | In-service register from in-service logic |
| win_valid_i | input | 1 | Resolver has an eligible pin |
| win_pin_i | input | 3 | Resolver winning pin |
| poll_ack_o | output | 1 | Poll read acknowledged a pin |
| poll_pin_o | output | 3 | Pin acknowledged by the poll read |
| init_clr_o | output | 1 | Setup started: clear requests, reset priority |
| ocw2_valid_o | output | 1 | Priority/EOI command forwarded |
| ocw2_o | output | 8 | Forwarded command byte |
| ready_o | output | 1 | Setup complete |
| imr_o | output | 8 | Interrupt mask |
| base_o | output | 8 | Base vector (low three bits zero) |
| aeoi_o | output | 1 | Auto end-of-interrupt mode |
| sfnm_o | output | 1 | Special fully nested mode |
| smm_o | output | 1 | Special mask mode |

## Verification
Every result of this block is registered once. A write changes the held state and the sideband pulses on the next clock edge. A read strobe puts its data on `rdata_o`, and any poll acknowledge, at the same edge. Each stimulus task drives at a falling edge and queues its expected items tagged with the cycle that follows. The monitor compares them at the next falling edge and flags any expectation that passed its due cycle without a compare. Ignored writes and refused setup words are checked one cycle later through the mask, base vector and ready outputs, and through a follow-up data write whose effect shows which setup state the block is in.

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq #(
  parameter bit IS_MASTER = 1'b1,
  parameter int DW = 8,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  input  logic          win_valid_i,
  input  logic [PW-1:0] win_pin_i,
  output logic          poll_ack_o,
  output logic [PW-1:0] poll_pin_o,
  output logic          init_clr_o,
  output logic          ocw2_valid_o,
  output logic [DW-1:0] ocw2_o,
  output logic          ready_o,
  output logic [DW-1:0] imr_o,
  output logic [DW-1:0] base_o,
  output logic          aeoi_o,
  output logic          sfnm_o,
  output logic          smm_o
);
  localparam logic [1:0] ST_W1 = 2'd0, ST_W2 = 2'd1, ST_W3 = 2'd2, ST_W4 = 2'd3;
  localparam logic [DW-1:0] BASE_MASK = {{(DW-PW){1'b1}}, {PW{1'b0}}};

  logic [1:0] st_q;
  logic       poll_q, rsel_q;

  wire cmd_wr  = wr_i && !addr_i;
  wire dat_wr  = wr_i &&  addr_i;
  wire start   = cmd_wr && wdata_i[4];
  wire op_wr   = cmd_wr && !wdata_i[4] && ready_o;
  wire ocw3_wr = op_wr && wdata_i[3];
  wire ocw2_wr = op_wr && !wdata_i[3];
  wire w1_ok   = wdata_i[0] && !wdata_i[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_W1;
      ready_o      <= 1'b0;
      imr_o        <= '0;
      base_o       <= '0;
      aeoi_o       <= 1'b0;
      sfnm_o       <= 1'b0;
      smm_o        <= 1'b0;
      poll_q       <= 1'b0;
      rsel_q       <= 1'b0;
      rdata_o      <= '0;
      poll_ack_o   <= 1'b0;
      poll_pin_o   <= '0;
      init_clr_o   <= 1'b0;
      ocw2_valid_o <= 1'b0;
      ocw2_o       <= '0;
    end else begin
      poll_ack_o   <= 1'b0;
      init_clr_o   <= start;
      ocw2_valid_o <= ocw2_wr;
      if (ocw2_wr) ocw2_o <= wdata_i;

      if (rd_i) begin
        if (poll_q) begin
          poll_q <= 1'b0;
          if (win_valid_i) begin
            rdata_o    <= DW'(8'h80) | DW'(win_pin_i);
            poll_ack_o <= 1'b1;
            poll_pin_o <= win_pin_i;
          end else begin
            rdata_o <= '0;
          end
        end else if (addr_i) begin
          rdata_o <= imr_o;
        end else begin
          rdata_o <= rsel_q ? isr_i : irr_i;
        end
      end

      if (start) begin
        imr_o   <= '0;
        poll_q  <= 1'b0;
        rsel_q  <= 1'b0;
        smm_o   <= 1'b0;
        ready_o <= 1'b0;
        st_q    <= w1_ok ? ST_W2 : ST_W1;
      end else if (ocw3_wr) begin
        if (wdata_i[6]) smm_o  <= wdata_i[5];
        if (wdata_i[1]) rsel_q <= wdata_i[0];
        if (wdata_i[2]) poll_q <= 1'b1;
      end

      if (dat_wr) begin
        case (st_q)
          ST_W2: begin
            base_o <= wdata_i & BASE_MASK;
            st_q   <= ST_W3;
          end
          ST_W3: st_q <= ST_W4;
          ST_W4: begin
            if (wdata_i[0]) begin
              aeoi_o  <= wdata_i[1];
              if (IS_MASTER) sfnm_o <= wdata_i[4];
              ready_o <= 1'b1;
              st_q    <= ST_W1;
            end
          end
          default: imr_o <= wdata_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       poll_ack_o,
  input logic [2:0] poll_pin_o,
  input logic       init_clr_o,
  input logic       ocw2_valid_o,
  input logic       ready_o,
  input logic [7:0] imr_o,
  input logic [7:0] base_o,
  input logic       sfnm_o,
  input logic       smm_o
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[4]) |=> (!ready_o && imr_o == 8'h00 && !smm_o && init_clr_o)); // R2
  AST_BAD_W1_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[4] && (wdata_i[1] || !wdata_i[0])) ##1 (wr_i && addr_i) |=> $stable(base_o)); // R3
  AST_BASE_ON_DATA_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_o) |-> $past(wr_i && addr_i)); // R4
  AST_READY_NEEDS_PM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(wr_i && addr_i && wdata_i[0])); // R6
  AST_SFNM_ON_W4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sfnm_o) |-> $past(wr_i && addr_i && wdata_i[0])); // R5
  AST_OCW2_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ocw2_valid_o |-> $past(ready_o && wr_i && !addr_i && !wdata_i[4] && !wdata_i[3])); // R8
  AST_POLL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack_o |-> (rdata_o[7] && rdata_o[2:0] == poll_pin_o && $past(rd_i))); // R10
endmodule

bind pic_cmd_seq pic_cmd_seq_chk u_chk (.*);

// File: tb/pic_cmd_seq_tb.sv
module pic_cmd_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, irr = '0, isr = '0;
  logic win_valid = 1'b0;
  logic [2:0] win_pin = '0;
  logic [7:0] rdata, ocw2, imr, base, s_rdata, s_ocw2, s_imr, s_base;
  logic poll_ack, init_clr, ocw2_v, ready, aeoi, sfnm, smm;
  logic s_poll_ack, s_init_clr, s_ocw2_v, s_ready, s_aeoi, s_sfnm, s_smm;
  logic [2:0] poll_pin, s_poll_pin;

  always #4 clk = ~clk;

  pic_cmd_seq #(.IS_MASTER(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .irr_i(irr), .isr_i(isr), .win_valid_i(win_valid), .win_pin_i(win_pin),
    .poll_ack_o(poll_ack), .poll_pin_o(poll_pin), .init_clr_o(init_clr),
    .ocw2_valid_o(ocw2_v), .ocw2_o(ocw2), .ready_o(ready), .imr_o(imr), .base_o(base),
    .aeoi_o(aeoi), .sfnm_o(sfnm), .smm_o(smm));

  pic_cmd_seq #(.IS_MASTER(1'b0)) u_slv (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(s_rdata), .irr_i(irr), .isr_i(isr), .win_valid_i(win_valid), .win_pin_i(win_pin),
    .poll_ack_o(s_poll_ack), .poll_pin_o(s_poll_pin), .init_clr_o(s_init_clr),
    .ocw2_valid_o(s_ocw2_v), .ocw2_o(s_ocw2), .ready_o(s_ready), .imr_o(s_imr), .base_o(s_base),
    .aeoi_o(s_aeoi), .sfnm_o(s_sfnm), .smm_o(s_smm));

  typedef enum int {O_RDATA, O_IMR, O_BASE, O_READY, O_AEOI, O_SFNM, O_SMM,
                    O_ACK, O_OCW2, O_INIT, O_SSFNM} obs_t;
  typedef struct { int due; obs_t what; int exp; string tag; } item_t;
  item_t q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observe(obs_t w);
    case (w)
      O_RDATA: return int'(rdata);
      O_IMR:   return int'(imr);
      O_BASE:  return int'(base);
      O_READY: return int'(ready);
      O_AEOI:  return int'(aeoi);
      O_SFNM:  return int'(sfnm);
      O_SMM:   return int'(smm);
      O_ACK:   return int'({poll_ack, poll_pin});
      O_OCW2:  return ocw2_v ? (256 | int'(ocw2)) : 0;
      O_INIT:  return int'(init_clr);
      default: return int'(s_sfnm);
    endcase
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = observe(it.what);
      n_cmp++;
      if (it.due < cyc || act != it.exp) begin
        n_bad++;
        $display("FAIL %s: %s actual 0x%0h expected 0x%0h", it.tag, it.what.name(), act, it.exp);
      end
    end
  end

  task automatic drive(input bit w, input bit r, input bit a, input logic [7:0] d);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
  endtask

  task automatic expect_next(input obs_t w, input int e, input string tag);
    item_t it;
    it.due = cyc + 1; it.what = w; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wcmd(input logic [7:0] d);  drive(1, 0, 0, d); endtask
  task automatic wdat(input logic [7:0] d);  drive(1, 0, 1, d); endtask
  task automatic rcmd();                     drive(0, 1, 0, 8'h00); endtask
  task automatic rdat();                     drive(0, 1, 1, 8'h00); endtask
  task automatic idle();                     drive(0, 0, 0, 8'h00); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    expect_next(O_READY, 0, "R1"); expect_next(O_IMR, 0, "R1");
    expect_next(O_BASE, 0, "R1"); expect_next(O_RDATA, 0, "R1");
    expect_next(O_SFNM, 0, "R1"); expect_next(O_SMM, 0, "R1");
    wdat(8'h5A);  expect_next(O_IMR, 8'h5A, "R7");
    wcmd(8'h11);  expect_next(O_READY, 0, "R2"); expect_next(O_IMR, 0, "R2");
                  expect_next(O_INIT, 1, "R2");
    wdat(8'h47);  expect_next(O_BASE, 8'h40, "R4"); expect_next(O_INIT, 0, "R2");
    wdat(8'hFF);  expect_next(O_READY, 0, "R5"); expect_next(O_IMR, 0, "R5");
                  expect_next(O_BASE, 8'h40, "R5");
    wdat(8'h12);  expect_next(O_READY, 0, "R6");
    wdat(8'h13);  expect_next(O_READY, 1, "R5"); expect_next(O_AEOI, 1, "R5");
                  expect_next(O_SFNM, 1, "R5"); expect_next(O_SSFNM, 0, "R5");
    wdat(8'h3C);  expect_next(O_IMR, 8'h3C, "R7"); expect_next(O_BASE, 8'h40, "R7");
    wcmd(8'h20);  expect_next(O_OCW2, 256 | 8'h20, "R8");
    idle();       expect_next(O_OCW2, 0, "R8");
    irr = 8'hA5; isr = 8'h18;
    rcmd();       expect_next(O_RDATA, 8'hA5, "R11");
    wcmd(8'h0B);
    rcmd();       expect_next(O_RDATA, 8'h18, "R11");
    rdat();       expect_next(O_RDATA, 8'h3C, "R11");
    wcmd(8'h09);
    rcmd();       expect_next(O_RDATA, 8'h18, "R9");
    wcmd(8'h68);  expect_next(O_SMM, 1, "R9");
    wcmd(8'h28);  expect_next(O_SMM, 1, "R9");
    wcmd(8'h48);  expect_next(O_SMM, 0, "R9");
    win_valid = 1'b1; win_pin = 3'd5;
    wcmd(8'h0C);  expect_next(O_OCW2, 0, "R9");
    rdat();       expect_next(O_RDATA, 8'h85, "R10"); expect_next(O_ACK, 8'hD, "R10");
    rdat();       expect_next(O_RDATA, 8'h3C, "R10"); expect_next(O_ACK, 8'h5, "R10");
    win_valid = 1'b0;
    wcmd(8'h0C);
    rcmd();       expect_next(O_RDATA, 8'h00, "R10"); expect_next(O_ACK, 8'h5, "R10");
    wcmd(8'h0B);
    wcmd(8'h13);  expect_next(O_READY, 0, "R3");
    wdat(8'h77);  expect_next(O_IMR, 8'h77, "R3"); expect_next(O_BASE, 8'h40, "R3");
    wcmd(8'h10);  expect_next(O_READY, 0, "R3");
    wdat(8'h99);  expect_next(O_IMR, 8'h99, "R3"); expect_next(O_BASE, 8'h40, "R3");
    wcmd(8'h20);  expect_next(O_OCW2, 0, "R8");
    wcmd(8'h11);
    wdat(8'h08);  expect_next(O_BASE, 8'h08, "R4");
    wdat(8'h04);
    wdat(8'h01);  expect_next(O_READY, 1, "R5"); expect_next(O_AEOI, 0, "R5");
                  expect_next(O_SFNM, 0, "R5");
    rcmd();       expect_next(O_RDATA, 8'hA5, "R2");
    idle(); idle(); idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule